// File: doc/BRIEF.md
# Converter Start-Up Sequencer

This block brings a step-down converter controller from off to regulation after enable rises. It opens with a calibration window of fixed length in which the power stage must not switch. At the close of that window it takes one snapshot of the configuration inputs: a 3-bit switching-frequency preset, a 2-bit ramp-length code and a light-load mode bit. Those values are held until the next enable cycle. After the window closes, the block enables switching and raises a reference DAC code one step at a time from zero to full scale. The slope is chosen so that the ramp lasts one of four durations, and each code doubles the previous duration.

When the code reaches full scale, the block reports that soft-start is complete. If forced continuous conduction was selected, the block waits for power good before it drives the forced-continuous output, so the controller runs in skip behaviour until then. A restart request from the fault logic runs the ramp again from zero and keeps the captured configuration. Dropping enable returns the block to off from any state.

Top module: `ss_sequencer`

## Requirements
- R1: After reset, dacCode, switchEn, ssDone, forcedCont, freqCode, rampCode and fccmCode are all zero.
- R2: When enable is high in the off state, calibration follows and lasts exactly CAL_CYCLES clocks with switchEn low. switchEn rises on the next clock.
- R3: freqSel, rampSel and fccmSel are sampled only in the last calibration clock. Later changes to these inputs leave freqCode, rampCode and fccmCode unchanged.
- R4: During the ramp, dacCode rises by exactly one after every BASE_PRESCALE·2^rampCode clocks and never exceeds FULL_CODE.
- R5: With rampCode = 0, 1, 2 or 3, switchEn stays high with ssDone low for FULL_CODE·BASE_PRESCALE·2^rampCode + 1 clocks. Each code therefore doubles the ramp length.
- R6: ssDone is high only after the ramp has finished, and dacCode equals FULL_CODE whenever ssDone is high.
- R7: fccmCode = 1 selects forced continuous conduction and 0 selects auto-skip. forcedCont rises one clock after a clock in which soft-start is done, fccmCode = 1 and powerGood = 1. It then stays high until the done state is left. With fccmCode = 0 it stays low.
- R8: If enable is low at a clock edge, the next cycle shows dacCode = 0 and switchEn, ssDone and forcedCont all low, whatever the state was before.
- R9: A restartReq during the ramp or after it clears dacCode, ssDone and forcedCont on the next clock. switchEn stays high, the captured codes are kept, and the full ramp runs again without a new calibration.
- R10: restartReq is ignored in the off state and during calibration, so calibration length and captured codes are unaffected.
- R11: Dropping enable and raising it again runs a new calibration that captures fresh configuration values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Converter enable; high runs the sequence, low forces off |
| freqSel | input | 3 | Frequency preset to capture (eight presets) |
| rampSel | input | 2 | Ramp-length code to capture |
| fccmSel | input | 1 | Light-load mode to capture: 1 forced continuous, 0 auto-skip |
| powerGood | input | 1 | Output-in-regulation indication |
| restartReq | input | 1 | Request from fault logic to rerun the ramp |
| dacCode | output | DAC_W | Reference DAC code |
| switchEn | output | 1 | Power stage may switch |
| freqCode | output | 3 | Captured frequency preset |
| rampCode | output | 2 | Captured ramp-length code |
| fccmCode | output | 1 | Captured light-load mode |
| ssDone | output | 1 | Soft-start finished |
| forcedCont | output | 1 | Forced continuous conduction active |

## Verification
The assertions check the following on every clock: the DAC code moves by at most one step outside a clear and stays within full scale, the captured codes hold outside the capture clock, disable forces the off state, and forced-continuous mode only appears in the done state with the mode bit set. A restart from ramp or done must also land back in the ramp. Exact lengths can only be shown by the bench scenarios: the calibration window, the four doubled ramp durations, and the delay of forced-continuous mode until power good. The same applies to the codes surviving a restart, the restart ignored during calibration, and the fresh capture after a re-enable.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_CAL  = 2'd1,
    ST_RAMP = 2'd2,
    ST_DONE = 2'd3
  } seqState_t;

  // Strobes from the sequencing control to the ramp datapath
  typedef struct packed {
    logic clrRamp;  // zero the DAC code and the prescaler
    logic stepEn;   // prescaler runs, DAC code may advance
    logic capture;  // latch the configuration inputs
  } seqStrobe_t;

endpackage

// File: rtl/ss_ramp_dp.sv
module ss_ramp_dp
  import ss_seq_pkg::*;
#(
  parameter int DAC_W         = 6,
  parameter int FULL_CODE     = 48,
  parameter int BASE_PRESCALE = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [2:0]       freqSel,
  input  logic [1:0]       rampSel,
  input  logic             fccmSel,
  output logic [DAC_W-1:0] dacCode,
  output logic [2:0]       freqCode,
  output logic [1:0]       rampCode,
  output logic             fccmCode,
  output logic             atFull
);

  localparam int PRE_W = $clog2(BASE_PRESCALE * 8) + 1;
  localparam logic [DAC_W-1:0] FULL = DAC_W'(FULL_CODE);

  logic [PRE_W-1:0] stepTable [4];
  logic [PRE_W-1:0] stepLast;
  logic [PRE_W-1:0] preCnt;

  // One terminal count per ramp code; each doubles the previous one
  genvar g;
  for (g = 0; g < 4; g++) begin : g_step
    assign stepTable[g] = PRE_W'((BASE_PRESCALE << g) - 1);
  end

  assign stepLast = stepTable[rampCode];
  assign atFull   = (dacCode == FULL);

  // Configuration snapshot, taken once per enable cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqCode <= '0;
      rampCode <= '0;
      fccmCode <= 1'b0;
    end else if (strobe.capture) begin
      freqCode <= freqSel;
      rampCode <= rampSel;
      fccmCode <= fccmSel;
    end
  end

  // Prescaled linear ramp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      dacCode <= '0;
    end else if (strobe.clrRamp) begin
      preCnt  <= '0;
      dacCode <= '0;
    end else if (strobe.stepEn) begin
      if (preCnt == stepLast) begin
        preCnt <= '0;
        if (!atFull) dacCode <= dacCode + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  p_dac_bounded_r4 : assert property (@(posedge clk) disable iff (!rstN)
    dacCode <= FULL);

  p_dac_step_r4 : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrRamp |=> (dacCode == $past(dacCode) || dacCode == $past(dacCode) + 1'b1));

  p_cfg_hold_r3 : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable({freqCode, rampCode, fccmCode}));

endmodule

// File: rtl/ss_seq_ctrl.sv
module ss_seq_ctrl
  import ss_seq_pkg::*;
#(
  parameter int CAL_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       restartReq,
  input  logic       powerGood,
  input  logic       fccmCode,
  input  logic       atFull,
  output seqStrobe_t strobe,
  output seqState_t  state,
  output logic       forcedCont
);

  localparam int CAL_W = (CAL_CYCLES > 1) ? $clog2(CAL_CYCLES) : 1;
  localparam logic [CAL_W-1:0] CAL_LAST = CAL_W'(CAL_CYCLES - 1);

  seqState_t        stateNext;
  logic [CAL_W-1:0] calCnt;
  logic             calDone;
  logic             restartOk;
  logic             fcNext;

  assign calDone   = (state == ST_CAL) && (calCnt == CAL_LAST);
  assign restartOk = restartReq && ((state == ST_RAMP) || (state == ST_DONE));

  always_comb begin
    stateNext = state;
    if (!enable) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:  stateNext = ST_CAL;
        ST_CAL:  if (calDone) stateNext = ST_RAMP;
        ST_RAMP: if (restartOk) stateNext = ST_RAMP;
                 else if (atFull) stateNext = ST_DONE;
        ST_DONE: if (restartOk) stateNext = ST_RAMP;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_comb begin
    strobe.capture = enable && calDone;
    strobe.stepEn  = enable && (state == ST_RAMP);
    strobe.clrRamp = !enable || restartOk || (state == ST_OFF) || (state == ST_CAL);
  end

  // Forced continuous conduction only after power good is seen in done
  assign fcNext = (stateNext == ST_DONE) && fccmCode && (forcedCont || powerGood);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_OFF;
      calCnt     <= '0;
      forcedCont <= 1'b0;
    end else begin
      state      <= stateNext;
      calCnt     <= (enable && state == ST_CAL && !calDone) ? calCnt + 1'b1 : '0;
      forcedCont <= fcNext;
    end
  end

  p_disable_off_r8 : assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_OFF && !forcedCont));

  p_fc_gate_r7 : assert property (@(posedge clk) disable iff (!rstN)
    forcedCont |-> (state == ST_DONE && fccmCode));

  p_restart_rerun_r9 : assert property (@(posedge clk) disable iff (!rstN)
    (enable && restartReq && (state == ST_RAMP || state == ST_DONE)) |=> state == ST_RAMP);

endmodule

// File: rtl/ss_sequencer.sv
module ss_sequencer
  import ss_seq_pkg::*;
#(
  parameter int CAL_CYCLES    = 20,
  parameter int DAC_W         = 6,
  parameter int FULL_CODE     = 48,
  parameter int BASE_PRESCALE = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [2:0]       freqSel,
  input  logic [1:0]       rampSel,
  input  logic             fccmSel,
  input  logic             powerGood,
  input  logic             restartReq,
  output logic [DAC_W-1:0] dacCode,
  output logic             switchEn,
  output logic [2:0]       freqCode,
  output logic [1:0]       rampCode,
  output logic             fccmCode,
  output logic             ssDone,
  output logic             forcedCont
);

  seqStrobe_t strobe;
  seqState_t  state;
  logic       atFull;

  ss_seq_ctrl #(.CAL_CYCLES(CAL_CYCLES)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .restartReq (restartReq),
    .powerGood  (powerGood),
    .fccmCode   (fccmCode),
    .atFull     (atFull),
    .strobe     (strobe),
    .state      (state),
    .forcedCont (forcedCont)
  );

  ss_ramp_dp #(
    .DAC_W         (DAC_W),
    .FULL_CODE     (FULL_CODE),
    .BASE_PRESCALE (BASE_PRESCALE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .freqSel  (freqSel),
    .rampSel  (rampSel),
    .fccmSel  (fccmSel),
    .dacCode  (dacCode),
    .freqCode (freqCode),
    .rampCode (rampCode),
    .fccmCode (fccmCode),
    .atFull   (atFull)
  );

  assign switchEn = (state == ST_RAMP) || (state == ST_DONE);
  assign ssDone   = (state == ST_DONE);

  p_done_full_r6 : assert property (@(posedge clk) disable iff (!rstN)
    ssDone |-> dacCode == DAC_W'(FULL_CODE));

endmodule

// File: tb/ss_sequencer_tb.sv
module ss_sequencer_tb;

  localparam int CAL   = 20;
  localparam int DW    = 6;
  localparam int FULL  = 48;
  localparam int BASE  = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [2:0]    freqSel = '0;
  logic [1:0]    rampSel = '0;
  logic          fccmSel = 1'b0;
  logic          powerGood = 1'b0;
  logic          restartReq = 1'b0;
  logic [DW-1:0] dacCode;
  logic          switchEn, ssDone, forcedCont, fccmCode;
  logic [2:0]    freqCode;
  logic [1:0]    rampCode;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #10 clk = ~clk;

  ss_sequencer #(.CAL_CYCLES(CAL), .DAC_W(DW), .FULL_CODE(FULL), .BASE_PRESCALE(BASE)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .freqSel(freqSel), .rampSel(rampSel),
    .fccmSel(fccmSel), .powerGood(powerGood), .restartReq(restartReq),
    .dacCode(dacCode), .switchEn(switchEn), .freqCode(freqCode), .rampCode(rampCode),
    .fccmCode(fccmCode), .ssDone(ssDone), .forcedCont(forcedCont)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // Behavioural reference: phase 0 off, 1 calibrating, 2 ramping, 3 done
  int mPhase = 0, mCal = 0, mPre = 0, mDac = 0, mFreq = 0, mRamp = 0, mFccm = 0, mFc = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mCal = 0; mPre = 0; mDac = 0; mFreq = 0; mRamp = 0; mFccm = 0; mFc = 0;
    end else if (!enable) begin
      mPhase = 0; mCal = 0; mPre = 0; mDac = 0; mFc = 0;
    end else begin
      case (mPhase)
        0: begin mPhase = 1; mCal = 0; end
        1: begin
          if (mCal == CAL - 1) begin
            mFreq = freqSel; mRamp = rampSel; mFccm = fccmSel;
            mPhase = 2; mPre = 0; mDac = 0;
          end else mCal++;
        end
        2: begin
          if (restartReq) begin mPre = 0; mDac = 0; end
          else if (mDac == FULL) begin mPhase = 3; mFc = mFccm & powerGood; end
          else if (mPre == (BASE << mRamp) - 1) begin mPre = 0; mDac++; end
          else mPre++;
        end
        default: begin
          if (restartReq) begin mPhase = 2; mPre = 0; mDac = 0; mFc = 0; end
          else mFc = mFccm & (mFc | powerGood);
        end
      endcase
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 dacCode", dacCode, mDac);
      chk("R2 switchEn", switchEn, (mPhase >= 2) ? 1 : 0);
      chk("R6 ssDone", ssDone, (mPhase == 3) ? 1 : 0);
      chk("R3 freqCode", freqCode, mFreq);
      chk("R3 rampCode", rampCode, mRamp);
      chk("R3 fccmCode", fccmCode, mFccm);
      chk("R7 forcedCont", forcedCont, mFc);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finishRun();
    end
  end

  // Counts calibration clocks; pulses restartReq at count pulseAt
  task automatic waitCal(input int pulseAt, output int n);
    n = 0;
    @(negedge clk);
    while (!switchEn) begin
      n++;
      restartReq = (n == pulseAt);
      @(negedge clk);
    end
    restartReq = 1'b0;
  endtask

  // Called on the first ramp clock; returns clocks spent ramping
  task automatic measureRamp(output int len);
    len = 1;
    @(negedge clk);
    while (!ssDone) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    int n;
    int len;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 dacCode", dacCode, 0);
    chk("R1 switchEn", switchEn, 0);
    chk("R1 ssDone", ssDone, 0);
    chk("R1 forcedCont", forcedCont, 0);
    chk("R1 codes", {freqCode, rampCode, fccmCode}, 0);

    // Scenario A: preset 5, shortest ramp, forced continuous
    freqSel = 3'd5; rampSel = 2'd0; fccmSel = 1'b1; powerGood = 1'b0;
    enable = 1'b1;
    waitCal(0, n);
    chk("R2 calibration length", n, CAL);
    freqSel = 3'd2; rampSel = 2'd3; fccmSel = 1'b0;  // R3: too late to matter
    measureRamp(len);
    chk("R5 ramp length code0", len, FULL * BASE + 1);
    chk("R3 freq kept", freqCode, 5);
    chk("R3 ramp kept", rampCode, 0);
    repeat (10) @(negedge clk);
    chk("R7 no forced mode before powerGood", forcedCont, 0);
    powerGood = 1'b1;
    @(negedge clk);
    chk("R7 forced mode after powerGood", forcedCont, 1);

    // R9: restart from done
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    chk("R9 dac cleared", dacCode, 0);
    chk("R9 switching kept", switchEn, 1);
    chk("R9 done cleared", ssDone, 0);
    chk("R9 forced cleared", forcedCont, 0);
    chk("R9 freq kept", freqCode, 5);
    measureRamp(len);
    chk("R9 ramp rerun length", len, FULL * BASE + 1);

    // R8: drop enable mid-ramp
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    repeat (20) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R8 dac cleared", dacCode, 0);
    chk("R8 switching off", switchEn, 0);
    chk("R8 done low", ssDone, 0);
    repeat (4) @(negedge clk);

    // Scenario B: fresh capture, restart during calibration ignored
    freqSel = 3'd6; rampSel = 2'd1; fccmSel = 1'b0; powerGood = 1'b1;
    enable = 1'b1;
    waitCal(3, n);
    chk("R10 restart ignored in calibration", n, CAL);
    chk("R11 new freq captured", freqCode, 6);
    measureRamp(len);
    chk("R5 ramp length code1", len, FULL * BASE * 2 + 1);
    repeat (5) @(negedge clk);
    chk("R7 auto-skip keeps forced low", forcedCont, 0);

    // Scenario C: codes 2 and 3 with powerGood already high
    enable = 1'b0;
    @(negedge clk);
    rampSel = 2'd2; fccmSel = 1'b1; freqSel = 3'd7;
    enable = 1'b1;
    waitCal(0, n);
    measureRamp(len);
    chk("R5 ramp length code2", len, FULL * BASE * 4 + 1);
    chk("R7 forced with done", forcedCont, 1);
    enable = 1'b0;
    @(negedge clk);
    rampSel = 2'd3;
    enable = 1'b1;
    waitCal(0, n);
    measureRamp(len);
    chk("R5 ramp length code3", len, FULL * BASE * 8 + 1);
    chk("R11 freq recaptured", freqCode, 7);
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule